// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the fetch side of a transmit DMA engine. It walks a chain of two-word descriptors in a word-addressed memory and passes each frame descriptor's buffer pointer and length to a transmit MAC. A descriptor is a control word followed by a pointer word. The descriptor type sits in control bits 31:28 and the byte count in bits 11:0. The walker obeys four type codes. A link (0x9) redirects the walk to the address held in its pointer word. A frame (0x7) is sent and then handed back to software as empty (0x3). An empty descriptor (0x3) or an end-of-set descriptor (0xA) ends the walk.

Software writes the descriptors and pulses the start input. On the first start after reset, and on any start after a fault, the walk begins at the base table entry, which normally links to a ring of transmit descriptors. On any other start the walk resumes at the descriptor that stopped the previous walk. Software therefore refills that slot and the slots after it, then starts again. Completion is signalled only by the rewritten type field, which software polls. Two faults end a walk and raise a sticky error flag: a link that leads directly to another link, and any type code other than the four listed. This stops a malformed chain from spinning forever.

The memory port has a fixed latency of one cycle. Read data is valid in the cycle after a read request, and writes take effect at the request edge.

Top module: `txw_top`

## Requirements
- R1: After reset, txActive, chainErr, frmReq, memReq and memWe are all 0.
- R2: A startSet pulse in idle sets txActive, and txActive reads 1 at the next clock. The first start after reset fetches the control word at baseAddr and the pointer word at baseAddr+1.
- R3: Control bits 31:28 hold the type. For type 0x9 the next descriptor is at the word address in the low bits of its pointer word. For type 0x7 the frame is offered with frmPtr set to the pointer word and frmLen set to control bits 11:0.
- R4: Frames are offered one at a time in chain order. frmReq stays high, with frmPtr and frmLen stable, until frmDone is seen.
- R5: After frmDone the descriptor's control word is rewritten with type 0x3 and bits 27:0 unchanged. The walk then continues at the next descriptor, two words further on.
- R6: A descriptor of type 0x3 or 0xA ends the walk with txActive cleared, no frame offered, no write to memory, and chainErr unchanged.
- R7: A start that follows a normal stop resumes at the descriptor that ended the previous walk, not at the base table.
- R8: A link whose target is also a link ends the walk with chainErr set and txActive cleared, and no frame is offered.
- R9: A type code other than 0x3, 0x7, 0x9 or 0xA ends the walk with chainErr set and txActive cleared, and that descriptor is not rewritten.
- R10: chainErr holds while idle and is cleared only when a new start is accepted. A start after a fault begins again at the base table.
- R11: A startSet pulse while txActive is 1 has no effect on the walk or on the frames offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSet | input | 1 | Pulse that requests a walk; ignored while a walk is active |
| baseAddr | input | AW | Word address of the base table entry |
| txActive | output | 1 | Start request bit; clears when the walk ends |
| chainErr | output | 1 | Sticky malformed-chain flag |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the access |
| memAddr | output | AW | Word address of the access |
| memWdata | output | 32 | Write data (rewritten control word) |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| frmReq | output | 1 | Frame offered to the MAC |
| frmPtr | output | 32 | Buffer pointer of the offered frame |
| frmLen | output | 12 | Byte count of the offered frame |
| frmDone | input | 1 | MAC reports the offered frame as sent |

## Verification
The bench builds the walker with AW = 8 against a 256-word memory. The base table sits at word 0x10, and an eight-slot ring at 0x40 ends in a link back to its first slot. With this memory size, the tests can refill the ring across its closing link, so the order of resumed frames is observable as it wraps from slot 6 to slot 0. The same setup forces the two fault paths by turning ring slots into a link-to-link pair or an undefined code, then confirms that the next start falls back to the base table. A MAC stub holds each request for several cycles. This exposes the request-hold rule and allows a second start pulse to land during an active walk.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W = 12;
  localparam int TYPE_LO = 28;
  localparam int DESC_WORDS = 2;

  localparam logic [3:0] DT_EMPTY = 4'h3;
  localparam logic [3:0] DT_FRAME = 4'h7;
  localparam logic [3:0] DT_LINK = 4'h9;
  localparam logic [3:0] DT_EOS = 4'hA;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_TAKEPTR, S_SEND, S_WBACK
  } txw_state_e;

  typedef struct packed {
    logic loadBase;
    logic rdCtrl;
    logic loadCtrl;
    logic rdPtr;
    logic loadLink;
    logic loadFrame;
    logic sending;
    logic wrBack;
    logic advance;
  } txw_strobe_t;
endpackage

// File: rtl/txw_datapath.sv
module txw_datapath
  import txw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txw_strobe_t       st,
  input  logic [AW-1:0]     baseAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        liveType,
  output logic [3:0]        heldType,
  output logic [DATA_W-1:0] frmPtr,
  output logic [LEN_W-1:0]  frmLen
);
  localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

  logic [AW-1:0]     curAddr;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] ptrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      ctrlReg <= '0;
      ptrReg  <= '0;
    end else begin
      if (st.loadBase)       curAddr <= baseAddr;
      else if (st.loadLink)  curAddr <= memRdata[AW-1:0];
      else if (st.advance)   curAddr <= curAddr + STEP;
      if (st.loadCtrl)  ctrlReg <= memRdata;
      if (st.loadFrame) ptrReg  <= memRdata;
    end
  end

  assign memReq   = st.rdCtrl | st.rdPtr | st.wrBack;
  assign memWe    = st.wrBack;
  assign memAddr  = st.rdPtr ? curAddr + AW'(1) : curAddr;
  assign memWdata = {DT_EMPTY, ctrlReg[TYPE_LO-1:0]};
  assign liveType = memRdata[DATA_W-1:TYPE_LO];
  assign heldType = ctrlReg[DATA_W-1:TYPE_LO];
  assign frmPtr   = ptrReg;
  assign frmLen   = ctrlReg[LEN_W-1:0];

  // R4: offered frame fields do not move while the offer is held
  a_r4_frame_stable: assert property (@(posedge clk) disable iff (!rstN)
    st.sending && $past(st.sending) |-> $stable(frmPtr) && $stable(frmLen));
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl
  import txw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSet,
  input  logic [3:0]  liveType,
  input  logic [3:0]  heldType,
  input  logic        frmDone,
  output txw_strobe_t st,
  output logic        txActive,
  output logic        chainErr,
  output logic        frmReq
);
  txw_state_e state, nxt;
  logic prevLink, resumeOk;
  logic accept, doStop, doFault, isLink, isFrame;

  assign accept  = (state == S_IDLE) && startSet;
  assign isLink  = (liveType == DT_LINK);
  assign isFrame = (liveType == DT_FRAME);

  always_comb begin
    st      = '0;
    nxt     = state;
    doStop  = 1'b0;
    doFault = 1'b0;
    case (state)
      S_IDLE: if (accept) begin
        st.loadBase = !resumeOk;
        nxt = S_FETCH;
      end
      S_FETCH: begin
        st.rdCtrl = 1'b1;
        nxt = S_DECODE;
      end
      S_DECODE: begin
        st.loadCtrl = 1'b1;
        if ((isLink && !prevLink) || isFrame) begin
          st.rdPtr = 1'b1;
          nxt = S_TAKEPTR;
        end else if (liveType == DT_EMPTY || liveType == DT_EOS) begin
          doStop = 1'b1;
          nxt = S_IDLE;
        end else begin
          doFault = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_TAKEPTR: begin
        if (heldType == DT_LINK) begin
          st.loadLink = 1'b1;
          nxt = S_FETCH;
        end else begin
          st.loadFrame = 1'b1;
          nxt = S_SEND;
        end
      end
      S_SEND: begin
        st.sending = 1'b1;
        if (frmDone) nxt = S_WBACK;
      end
      S_WBACK: begin
        st.wrBack  = 1'b1;
        st.advance = 1'b1;
        nxt = S_FETCH;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      txActive <= 1'b0;
      chainErr <= 1'b0;
      prevLink <= 1'b0;
      resumeOk <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        txActive <= 1'b1;
        chainErr <= 1'b0;
        prevLink <= 1'b0;
      end
      if (doStop) begin
        txActive <= 1'b0;
        resumeOk <= 1'b1;
      end
      if (doFault) begin
        txActive <= 1'b0;
        chainErr <= 1'b1;
        resumeOk <= 1'b0;
      end
      if (state == S_TAKEPTR) prevLink <= (heldType == DT_LINK);
    end
  end

  assign frmReq = st.sending;

  // R4: an offer is held until the MAC reports it done
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    frmReq && !frmDone |=> frmReq);
  // R4: frames are only offered inside an active walk
  a_r4_req_active: assert property (@(posedge clk) disable iff (!rstN)
    frmReq |-> txActive);
  // R5: a rewrite only follows a completed frame
  a_r5_wb_after_done: assert property (@(posedge clk) disable iff (!rstN)
    st.wrBack |-> $past(frmReq && frmDone));
  // R8: raising the fault flag ends the walk
  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainErr) |-> !txActive);
endmodule

// File: rtl/txw_top.sv
module txw_top
  import txw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startSet,
  input  logic [AW-1:0] baseAddr,
  output logic          txActive,
  output logic          chainErr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          frmReq,
  output logic [31:0]   frmPtr,
  output logic [11:0]   frmLen,
  input  logic          frmDone
);
  txw_strobe_t st;
  logic [3:0] liveType, heldType;

  txw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startSet(startSet),
    .liveType(liveType), .heldType(heldType), .frmDone(frmDone),
    .st(st), .txActive(txActive), .chainErr(chainErr), .frmReq(frmReq)
  );

  txw_datapath #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .baseAddr(baseAddr),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata),
    .liveType(liveType), .heldType(heldType),
    .frmPtr(frmPtr), .frmLen(frmLen)
  );

  // R6: writes to memory only happen while a walk is active
  a_r6_write_active: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq && txActive);
endmodule

// File: tb/txw_top_tb_top.sv
`timescale 1ns/1ps
module txw_top_tb_top;
  localparam int AW = 8;
  localparam int MAC_DLY = 3;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [7:0] RING = 8'h40;

  logic clk = 1'b0, rstN = 1'b0, startSet = 1'b0;
  logic txActive, chainErr, memReq, memWe, frmReq, frmDone;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata, frmPtr;
  logic [11:0] frmLen;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  txw_top #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .startSet(startSet), .baseAddr(BASE),
    .txActive(txActive), .chainErr(chainErr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .frmReq(frmReq), .frmPtr(frmPtr), .frmLen(frmLen), .frmDone(frmDone)
  );

  // memory model: one-cycle read latency, bench writes through a side port
  logic [31:0] mem [0:255];
  logic tbWe = 1'b0;
  logic [7:0] tbAddr = '0;
  logic [31:0] tbData = '0;
  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memReq && memWe) mem[memAddr] <= memWdata;
    if (memReq && !memWe) memRdata <= mem[memAddr];
  end

  // MAC stub: accepts each offer after MAC_DLY cycles and logs it
  logic [31:0] logPtr [0:31];
  logic [11:0] logLen [0:31];
  int logCnt = 0;
  int macCnt = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      frmDone <= 1'b0;
      macCnt <= 0;
    end else begin
      frmDone <= 1'b0;
      if (frmReq && !frmDone) begin
        if (macCnt == MAC_DLY) begin
          frmDone <= 1'b1;
          macCnt <= 0;
          logPtr[logCnt % 32] <= frmPtr;
          logLen[logCnt % 32] <= frmLen;
          logCnt <= logCnt + 1;
        end else macCnt <= macCnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putDesc(input logic [7:0] a, input logic [3:0] t,
                         input logic [11:0] len, input logic [31:0] ptr);
    wr(a, {t, 16'h0, len});
    wr(a + 8'd1, ptr);
  endtask

  function automatic logic [7:0] slot(input int i);
    return RING + 8'(2 * i);
  endfunction

  // start a walk, optionally pulse start again mid-walk, wait for the end
  task automatic runWalk(input bit extraPulse);
    int n;
    @(negedge clk); startSet = 1'b1;
    @(negedge clk); startSet = 1'b0;
    check("R2 start bit set", {31'b0, txActive}, 32'd1);
    if (extraPulse) begin
      repeat (3) @(negedge clk);
      startSet = 1'b1;
      @(negedge clk); startSet = 1'b0;
    end
    n = 0;
    while (txActive && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) check("walk timeout", 32'd1, 32'd0);
  endtask

  task automatic checkFrame(input string req, input int idx,
                            input logic [31:0] ptr, input logic [11:0] len);
    check(req, logPtr[idx % 32], ptr);
    check(req, {20'b0, logLen[idx % 32]}, {20'b0, len});
  endtask

  task automatic testReset();
    check("R1 txActive", {31'b0, txActive}, 0);
    check("R1 chainErr", {31'b0, chainErr}, 0);
    check("R1 frmReq", {31'b0, frmReq}, 0);
    check("R1 memReq", {31'b0, memReq | memWe}, 0);
  endtask

  task automatic testFirstBatch();
    int c0 = logCnt;
    putDesc(slot(0), 4'h7, 12'h5EE, 32'h0000_1000);
    putDesc(slot(1), 4'h7, 12'h040, 32'h0000_2000);
    putDesc(slot(2), 4'h7, 12'h001, 32'h0000_3000);
    runWalk(1'b1);
    check("R4 R11 frame count", logCnt - c0, 3);
    checkFrame("R3 R4 frame0", c0, 32'h1000, 12'h5EE);
    checkFrame("R4 frame1", c0 + 1, 32'h2000, 12'h040);
    checkFrame("R4 frame2", c0 + 2, 32'h3000, 12'h001);
    check("R5 writeback slot0", mem[slot(0)], 32'h3000_05EE);
    check("R5 writeback slot2", mem[slot(2)], 32'h3000_0001);
    check("R6 no error", {31'b0, chainErr}, 0);
    repeat (10) @(negedge clk);
    check("R11 no extra walk", logCnt - c0, 3);
  endtask

  task automatic testWrap();
    int c0 = logCnt;
    for (int i = 3; i < 7; i++) putDesc(slot(i), 4'h7, 12'(16 + i), 32'h4000 + 32'(i));
    putDesc(slot(0), 4'h7, 12'h0AA, 32'h0000_5000);
    runWalk(1'b0);
    check("R7 wrap count", logCnt - c0, 5);
    checkFrame("R7 resume slot3", c0, 32'h4003, 12'd19);
    checkFrame("R5 slot6", c0 + 3, 32'h4006, 12'd22);
    checkFrame("R3 R5 wrap through link", c0 + 4, 32'h5000, 12'h0AA);
  endtask

  task automatic testEos();
    int c0 = logCnt;
    wr(slot(1), 32'hA000_0000);
    runWalk(1'b0);
    check("R6 eos no frame", logCnt - c0, 0);
    check("R6 eos no error", {31'b0, chainErr}, 0);
    check("R6 eos not rewritten", mem[slot(1)], 32'hA000_0000);
    putDesc(slot(1), 4'h7, 12'h123, 32'h0000_9000);
    runWalk(1'b0);
    check("R7 resume after eos", logCnt - c0, 1);
    checkFrame("R7 resumed frame", c0, 32'h9000, 12'h123);
  endtask

  task automatic testLinkLink();
    int c0 = logCnt;
    putDesc(slot(2), 4'h9, 12'h0, {24'h0, slot(7)});
    runWalk(1'b0);
    check("R8 no frame", logCnt - c0, 0);
    check("R8 error set", {31'b0, chainErr}, 1);
    check("R8 stopped", {31'b0, txActive}, 0);
    repeat (6) @(negedge clk);
    check("R10 error sticky", {31'b0, chainErr}, 1);
  endtask

  task automatic testRestartBase();
    int c0 = logCnt;
    putDesc(slot(0), 4'h7, 12'h077, 32'h0000_A000);
    wr(slot(1), 32'h3000_0000);
    runWalk(1'b0);
    check("R10 error cleared", {31'b0, chainErr}, 0);
    check("R10 restart from base", logCnt - c0, 1);
    checkFrame("R10 base frame", c0, 32'hA000, 12'h077);
  endtask

  task automatic testUnknown();
    int c0 = logCnt;
    wr(slot(1), 32'h5000_0042);
    runWalk(1'b0);
    check("R9 no frame", logCnt - c0, 0);
    check("R9 error set", {31'b0, chainErr}, 1);
    check("R9 not rewritten", mem[slot(1)], 32'h5000_0042);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h3000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    for (int i = 1; i < 16; i++) putDesc(BASE + 8'(2 * i), 4'hA, 12'h0, 32'h0);
    putDesc(BASE, 4'h9, 12'h0, {24'h0, RING});
    putDesc(slot(7), 4'h9, 12'h0, {24'h0, RING});
    testFirstBatch();
    testWrap();
    testEos();
    testLinkLink();
    testRestartBase();
    testUnknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule